// File: doc/BRIEF.md
# DAC Conversion Sequencer with Automatic Power Gating

This block is the digital control sequencer that sits in front of a digital-to-analog converter cell. Software or a DMA engine writes a channel number and a sample into a single-entry holding register. The sequencer powers the analog cell up when there is work, waits a programmable start-up time, and then strobes one conversion per pending item. When no work is left, it powers the cell back down.

A fast wake-up option leaves the cell partly powered while idle, so that a shorter start-up count can be programmed. A maximum-speed option paces back-to-back conversions from an internal counter rather than from the end-of-conversion input, which saves two clock periods per conversion. In that mode the reported end-of-conversion flag lags by two more cycles. An optional refresh timer periodically reconverts the last value written to every channel, so that held analog levels are restored.

Top module: `dac_conv_seq`

## Requirements
- R1: After reset, and whenever no work is pending while fast wake-up is 0, `cell_en_o` and `cell_partial_o` are both 0. After reset `rdy_o` is 1 and `conv_o` and `eoc_flag_o` are 0.
- R2: A write accepted in cycle w starts the cell and produces the first `conv_o` pulse in cycle w+2+W. W is 8×`cfg_startup_i`, or 1 when that field is 0.
- R3: After the last pending item has been converted, the cell stays enabled for one extra cycle and then returns to its idle state.
- R4: With `cfg_fast_wake_i`=1 the idle state drives `cell_partial_o`=1 and `cell_en_o`=0. A write from that state sees the same w+2+W latency.
- R5: With `cfg_max_speed_i`=0, a conversion ends in the cycle in which `eoc_i` is high, and the next pending conversion is strobed in the following cycle.
- R6: With `cfg_max_speed_i`=1, `eoc_i` is ignored and each conversion lasts CONV_CYC-1 cycles. Back-to-back strobes are therefore CONV_CYC-1 cycles apart (5 with the defaults), against CONV_CYC+1 in normal mode when the cell answers CONV_CYC cycles after a strobe.
- R7: `eoc_flag_o` pulses 1 cycle after `eoc_i` in normal mode and 3 cycles after `eoc_i` in maximum-speed mode.
- R8: `rdy_o` is 1 exactly when the holding register is empty. A write made while `rdy_o` is 0 is ignored. The register empties in the cycle its conversion is strobed.
- R9: `conv_o` is a one-cycle pulse, and `conv_chan_o`/`conv_data_o` carry the converted channel and sample during that cycle. Written samples are served before refresh items.
- R10: A non-zero `cfg_refresh_i` sets a period P=`cfg_refresh_i`×1024 cycles. P cycles after the field becomes non-zero (and every P cycles after that), a refresh round is raised. The round converts the last written value of channels 0,1,2,3 in ascending order. If the cell is off, it is woken through the start-up path, so `cell_en_o` rises in cycle a+1026 when the field is set in cycle a with value 1.
- R11: `cfg_refresh_i`=0 disables refresh, and no refresh conversion is issued.
- R12: A write accepted while the cell is in start-up is kept and converted as soon as start-up ends, ahead of any pending refresh items.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DAC clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_startup_i | input | STW | Start-up wait in units of 8 clocks (0 = one clock) |
| cfg_fast_wake_i | input | 1 | Keep cell partly powered while idle |
| cfg_max_speed_i | input | 1 | Pace conversions with the internal counter |
| cfg_refresh_i | input | RFW | Refresh period in units of 1024 clocks, 0 = off |
| wr_valid_i | input | 1 | Write strobe for the holding register |
| wr_chan_i | input | CHW | Channel of the write |
| wr_data_i | input | DW | Sample of the write |
| rdy_o | output | 1 | Holding register empty |
| eoc_i | input | 1 | End-of-conversion from the analog cell |
| cell_en_o | output | 1 | Analog cell fully enabled |
| cell_partial_o | output | 1 | Analog cell in partial-power standby |
| conv_o | output | 1 | Conversion strobe |
| conv_chan_o | output | CHW | Channel being converted |
| conv_data_o | output | DW | Sample being converted |
| eoc_flag_o | output | 1 | End-of-conversion flag |

## Verification
On every cycle, the assertions check the following. No strobe leaves the off or standby states directly. A strobe always comes with an enabled cell and lasts one cycle. A full holding register keeps its contents against new writes. Refresh stays quiet while disabled. Maximum-speed conversions are not cut short by the end-of-conversion input, and the normal-mode flag follows that input. Exact latencies need the bench's scenarios: start-up counts, strobe spacing in both pacing modes, the extra flag delay in maximum-speed mode, the cycle at which a refresh wakes the cell, and the order of a refresh round with a write queued during start-up.

// File: rtl/dacs_pkg.sv
package dacs_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_STBY,
    ST_WAKE,
    ST_CONV,
    ST_ON
  } dacs_state_e;
endpackage

// File: rtl/dacs_hold_buf.sv
module dacs_hold_buf #(
  parameter int NCH = 4,
  parameter int DW  = 12,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_valid_i,
  input  logic [CHW-1:0] wr_chan_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           take_i,
  input  logic [CHW-1:0] ref_idx_i,
  output logic           hold_valid_o,
  output logic [CHW-1:0] hold_chan_o,
  output logic [DW-1:0]  hold_data_o,
  output logic [DW-1:0]  last_data_o
);
  logic [DW-1:0] last_q [NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_valid_o <= 1'b0;
      hold_chan_o  <= '0;
      hold_data_o  <= '0;
    end else if (take_i) begin
      hold_valid_o <= 1'b0;
    end else if (wr_valid_i && !hold_valid_o) begin
      hold_valid_o <= 1'b1;
      hold_chan_o  <= wr_chan_i;
      hold_data_o  <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) last_q[i] <= '0;
    end else if (take_i) begin
      last_q[hold_chan_o] <= hold_data_o;
    end
  end

  assign last_data_o = last_q[ref_idx_i];

  // R8: a full register keeps its item against new writes
  p_full_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_valid_o && !take_i) |=> (hold_valid_o && $stable(hold_data_o) && $stable(hold_chan_o)));
endmodule

// File: rtl/dacs_refresh_tmr.sv
module dacs_refresh_tmr #(
  parameter int RFW = 4,
  parameter int UL  = 10,
  parameter int NCH = 4,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [RFW-1:0] cfg_refresh_i,
  input  logic           ref_take_i,
  output logic           ref_pend_o,
  output logic [CHW-1:0] ref_idx_o
);
  localparam int PW = RFW + UL;
  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  logic [PW-1:0] cnt_q;
  logic          armed_q;
  logic          fire;
  logic [PW-1:0] period_m1;

  assign period_m1 = {cfg_refresh_i, {UL{1'b0}}} - PW'(1);
  assign fire      = armed_q && (cnt_q == '0) && (cfg_refresh_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cfg_refresh_i == '0) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!armed_q || cnt_q == '0) begin
      cnt_q   <= period_m1;
      armed_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q - PW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_pend_o <= 1'b0;
      ref_idx_o  <= '0;
    end else if (cfg_refresh_i == '0) begin
      ref_pend_o <= 1'b0;
      ref_idx_o  <= '0;
    end else begin
      if (ref_take_i) begin
        if (ref_idx_o == LAST_CH) begin
          ref_idx_o  <= '0;
          ref_pend_o <= 1'b0;
        end else begin
          ref_idx_o <= ref_idx_o + CHW'(1);
        end
      end
      if (fire) ref_pend_o <= 1'b1;
    end
  end

  // R11: disabled refresh never leaves a round pending
  p_ref_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_refresh_i == '0) |=> !ref_pend_o);
endmodule

// File: rtl/dacs_ctrl_fsm.sv
module dacs_ctrl_fsm
  import dacs_pkg::*;
#(
  parameter int STW      = 4,
  parameter int CONV_CYC = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [STW-1:0] cfg_startup_i,
  input  logic           cfg_fast_wake_i,
  input  logic           cfg_max_speed_i,
  input  logic           hold_valid_i,
  input  logic           ref_pend_i,
  input  logic           eoc_i,
  output logic           start_o,
  output logic           cell_en_o,
  output logic           cell_partial_o,
  output logic           conv_o
);
  localparam int SCW = STW + 3;
  localparam int CVW = $clog2(CONV_CYC);
  localparam logic [CVW-1:0] MAX_LAST = CVW'(CONV_CYC - 2);

  dacs_state_e state_q, state_d, idle_st;
  logic [SCW-1:0] wake_cnt_q, wake_len_m1;
  logic [CVW-1:0] cv_cnt_q;
  logic           pending, conv_done;

  assign pending     = hold_valid_i || ref_pend_i;
  assign idle_st     = cfg_fast_wake_i ? ST_STBY : ST_OFF;
  assign wake_len_m1 = (cfg_startup_i == '0) ? '0 : ({cfg_startup_i, 3'b000} - SCW'(1));
  assign conv_done   = cfg_max_speed_i ? (cv_cnt_q == MAX_LAST) : eoc_i;

  always_comb begin
    state_d = state_q;
    start_o = 1'b0;
    unique case (state_q)
      ST_OFF, ST_STBY: state_d = pending ? ST_WAKE : idle_st;
      ST_WAKE: if (wake_cnt_q == '0) begin
        if (pending) begin
          state_d = ST_CONV;
          start_o = 1'b1;
        end else state_d = ST_ON;
      end
      ST_CONV: if (conv_done) begin
        if (pending) start_o = 1'b1;
        else state_d = ST_ON;
      end
      ST_ON: if (pending) begin
        state_d = ST_CONV;
        start_o = 1'b1;
      end else state_d = idle_st;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_OFF;
      wake_cnt_q <= '0;
      cv_cnt_q   <= '0;
      conv_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      conv_o  <= start_o;
      if (state_q != ST_WAKE) wake_cnt_q <= wake_len_m1;
      else if (wake_cnt_q != '0) wake_cnt_q <= wake_cnt_q - SCW'(1);
      if (start_o) cv_cnt_q <= '0;
      else if (state_q == ST_CONV && cv_cnt_q != MAX_LAST) cv_cnt_q <= cv_cnt_q + CVW'(1);
    end
  end

  assign cell_en_o      = (state_q == ST_WAKE) || (state_q == ST_CONV) || (state_q == ST_ON);
  assign cell_partial_o = (state_q == ST_STBY);

  // R2: no strobe straight out of a powered-down state
  p_no_cold_conv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF || state_q == ST_STBY) |=> !conv_o);
  // R9: strobe only with the cell on, one cycle wide
  p_conv_powered_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> cell_en_o);
  p_conv_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |=> !conv_o);
  // R6: counter pacing is not cut short by eoc_i
  p_max_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_max_speed_i && state_q == ST_CONV && cv_cnt_q < MAX_LAST) |=> (state_q == ST_CONV && !conv_o));
endmodule

// File: rtl/dac_conv_seq.sv
module dac_conv_seq #(
  parameter int NCH      = 4,
  parameter int DW       = 12,
  parameter int STW      = 4,
  parameter int RFW      = 4,
  parameter int CONV_CYC = 6,
  parameter int CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [STW-1:0] cfg_startup_i,
  input  logic           cfg_fast_wake_i,
  input  logic           cfg_max_speed_i,
  input  logic [RFW-1:0] cfg_refresh_i,
  input  logic           wr_valid_i,
  input  logic [CHW-1:0] wr_chan_i,
  input  logic [DW-1:0]  wr_data_i,
  output logic           rdy_o,
  input  logic           eoc_i,
  output logic           cell_en_o,
  output logic           cell_partial_o,
  output logic           conv_o,
  output logic [CHW-1:0] conv_chan_o,
  output logic [DW-1:0]  conv_data_o,
  output logic           eoc_flag_o
);
  logic           start, hold_valid, ref_pend, take_hold, take_ref;
  logic [CHW-1:0] hold_chan, ref_idx;
  logic [DW-1:0]  hold_data, last_data;
  logic [2:0]     eoc_dly_q;

  assign take_hold = start && hold_valid;
  assign take_ref  = start && !hold_valid;
  assign rdy_o     = !hold_valid;

  dacs_hold_buf #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_hold (
    .clk_i, .rst_ni, .wr_valid_i, .wr_chan_i, .wr_data_i,
    .take_i(take_hold), .ref_idx_i(ref_idx),
    .hold_valid_o(hold_valid), .hold_chan_o(hold_chan),
    .hold_data_o(hold_data), .last_data_o(last_data)
  );

  dacs_refresh_tmr #(.RFW(RFW), .UL(10), .NCH(NCH), .CHW(CHW)) u_ref (
    .clk_i, .rst_ni, .cfg_refresh_i, .ref_take_i(take_ref),
    .ref_pend_o(ref_pend), .ref_idx_o(ref_idx)
  );

  dacs_ctrl_fsm #(.STW(STW), .CONV_CYC(CONV_CYC)) u_fsm (
    .clk_i, .rst_ni, .cfg_startup_i, .cfg_fast_wake_i, .cfg_max_speed_i,
    .hold_valid_i(hold_valid), .ref_pend_i(ref_pend), .eoc_i,
    .start_o(start), .cell_en_o, .cell_partial_o, .conv_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_chan_o <= '0;
      conv_data_o <= '0;
      eoc_dly_q   <= '0;
    end else begin
      eoc_dly_q <= {eoc_dly_q[1:0], eoc_i};
      if (start) begin
        conv_chan_o <= hold_valid ? hold_chan : ref_idx;
        conv_data_o <= hold_valid ? hold_data : last_data;
      end
    end
  end

  // max-speed flag is two cycles later than the normal one
  assign eoc_flag_o = cfg_max_speed_i ? eoc_dly_q[2] : eoc_dly_q[0];

  // R7: normal-mode flag follows eoc_i by one cycle
  p_eoc_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i |=> (cfg_max_speed_i || eoc_flag_o));
endmodule

// File: tb/dac_conv_seq_bench.sv
module dac_conv_seq_bench;
  localparam int C = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_su = '0;
  logic        cfg_fast = 1'b0;
  logic        cfg_max = 1'b0;
  logic [3:0]  cfg_rf = '0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_chan = '0;
  logic [11:0] wr_data = '0;
  logic        rdy, eoc = 1'b0, cell_en, cell_part, conv, eoc_flag;
  logic [1:0]  conv_chan;
  logic [11:0] conv_data;

  always #2 clk = ~clk;

  dac_conv_seq u_dac_conv_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_startup_i(cfg_su), .cfg_fast_wake_i(cfg_fast),
    .cfg_max_speed_i(cfg_max), .cfg_refresh_i(cfg_rf), .wr_valid_i(wr_valid),
    .wr_chan_i(wr_chan), .wr_data_i(wr_data), .rdy_o(rdy), .eoc_i(eoc),
    .cell_en_o(cell_en), .cell_partial_o(cell_part), .conv_o(conv),
    .conv_chan_o(conv_chan), .conv_data_o(conv_data), .eoc_flag_o(eoc_flag)
  );

  typedef struct packed { logic [1:0] ch; logic [11:0] d; } item_t;
  item_t exp_q[$];
  logic [11:0] mdl_last [4];

  int cyc = 0, n_chk = 0, n_bad = 0;
  int conv_cnt = 0, conv_cyc_last = 0, conv_cyc_prev = 0;
  int eoc_hi_cyc = 0, flag_cyc = 0, eoc_cd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // analog cell model: eoc_i high C cycles after a strobe
  always @(negedge clk) begin
    eoc <= 1'b0;
    if (conv) eoc_cd = C;
    else if (eoc_cd > 0) begin
      eoc_cd--;
      if (eoc_cd == 0) begin
        eoc <= 1'b1;
        eoc_hi_cyc = cyc;
      end
    end
    if (eoc_flag) flag_cyc = cyc;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && conv) begin
      conv_cnt++;
      conv_cyc_prev = conv_cyc_last;
      conv_cyc_last = cyc;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected conversion", int'(conv_data), -1);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(conv_chan == e.ch, "R9 conv channel", int'(conv_chan), int'(e.ch));
        chk(conv_data == e.d, "R9 conv data", int'(conv_data), int'(e.d));
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] ch, input logic [11:0] d,
                          output int wcyc, output bit acc);
    @(negedge clk);
    wcyc = cyc;
    acc  = rdy;
    wr_valid = 1'b1; wr_chan = ch; wr_data = d;
    if (acc) begin
      exp_q.push_back('{ch: ch, d: d});
      mdl_last[ch] = d;
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_conv();
    for (int i = 0; i < 400; i++) begin
      if (conv) return;
      @(negedge clk);
    end
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 600; i++) begin
      if (exp_q.size() == 0) break;
      @(negedge clk);
    end
    wait_cyc(20);
  endtask

  initial begin
    int w, w2, a, n0;
    bit acc;
    for (int i = 0; i < 4; i++) mdl_last[i] = '0;
    wait_cyc(3);
    chk(cell_en == 0 && cell_part == 0, "R1 reset cell off", int'(cell_en), 0);
    chk(rdy == 1, "R8 reset ready", int'(rdy), 1);
    chk(conv == 0 && eoc_flag == 0, "R1 reset strobes low", int'(conv), 0);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(3);

    // R2: startup 0 -> one-cycle wait
    do_write(2'd1, 12'h123, w, acc);
    wait_drain();
    chk(conv_cyc_last == w + 3, "R2 latency su=0", conv_cyc_last, w + 3);
    chk(cell_en == 0 && cell_part == 0, "R3 back to off", int'(cell_en), 0);

    // R2: startup 2 -> 16 cycles
    cfg_su = 4'd2;
    do_write(2'd2, 12'h0A5, w, acc);
    wait_drain();
    chk(conv_cyc_last == w + 18, "R2 latency su=2", conv_cyc_last, w + 18);

    // R5: normal pacing back to back
    cfg_su = 4'd0;
    do_write(2'd0, 12'h111, w, acc);
    wait_conv();
    do_write(2'd3, 12'h222, w2, acc);
    wait_drain();
    chk(conv_cyc_last - conv_cyc_prev == C + 1, "R5 normal spacing", conv_cyc_last - conv_cyc_prev, C + 1);
    chk(flag_cyc - eoc_hi_cyc == 1, "R7 normal flag delay", flag_cyc - eoc_hi_cyc, 1);

    // R6: max-speed pacing
    cfg_max = 1'b1;
    wait_cyc(2);
    do_write(2'd1, 12'h333, w, acc);
    wait_conv();
    do_write(2'd2, 12'h444, w2, acc);
    wait_drain();
    chk(conv_cyc_last - conv_cyc_prev == C - 1, "R6 max spacing", conv_cyc_last - conv_cyc_prev, C - 1);

    // R7: max-speed flag two cycles later
    do_write(2'd3, 12'h555, w, acc);
    wait_drain();
    chk(flag_cyc - eoc_hi_cyc == 3, "R7 max flag delay", flag_cyc - eoc_hi_cyc, 3);
    cfg_max = 1'b0;

    // R8: write while full is ignored
    cfg_su = 4'd4;
    n0 = conv_cnt;
    do_write(2'd0, 12'h666, w, acc);
    chk(acc == 1, "R8 first write accepted", int'(acc), 1);
    do_write(2'd1, 12'h777, w2, acc);
    chk(acc == 0, "R8 ready low when full", int'(acc), 0);
    wait_drain();
    chk(conv_cnt - n0 == 1, "R8 ignored write not converted", conv_cnt - n0, 1);
    chk(rdy == 1, "R8 ready after conversion", int'(rdy), 1);

    // R4: fast wake-up standby
    cfg_su = 4'd0;
    cfg_fast = 1'b1;
    wait_cyc(4);
    chk(cell_part == 1 && cell_en == 0, "R4 standby partial power", int'(cell_part), 1);
    do_write(2'd2, 12'h888, w, acc);
    wait_drain();
    chk(conv_cyc_last == w + 3, "R4 latency from standby", conv_cyc_last, w + 3);
    chk(cell_part == 1 && cell_en == 0, "R4 back to standby", int'(cell_en), 0);
    cfg_fast = 1'b0;
    wait_cyc(4);
    chk(cell_part == 0 && cell_en == 0, "R1 idle off without fast wake", int'(cell_part), 0);

    // R10 / R12: refresh wakes the cell, write during startup goes first
    cfg_su = 4'd15;
    @(negedge clk);
    a = cyc;
    cfg_rf = 4'd1;
    for (int i = 0; i < 1200; i++) begin
      if (cell_en) break;
      @(negedge clk);
    end
    chk(cyc == a + 1026, "R10 refresh wake cycle", cyc, a + 1026);
    n0 = conv_cnt;
    do_write(2'd2, 12'h9AB, w, acc);
    chk(acc == 1, "R12 write during startup accepted", int'(acc), 1);
    for (int i = 0; i < 4; i++) exp_q.push_back('{ch: 2'(i), d: mdl_last[i]});
    wait_drain();
    chk(conv_cnt - n0 == 5, "R10 refresh round length", conv_cnt - n0, 5);
    chk(exp_q.size() == 0, "R12 queue drained", exp_q.size(), 0);

    // R11: refresh disabled
    cfg_rf = 4'd0;
    n0 = conv_cnt;
    wait_cyc(2200);
    chk(conv_cnt == n0, "R11 no refresh when disabled", conv_cnt - n0, 0);
    chk(cell_en == 0, "R11 cell stays off", int'(cell_en), 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule